// File: doc/BRIEF.md
# Indexed Colour Palette Port

This block holds a 256-entry colour lookup table. Each entry has a red, a green and a blue channel of 6 bits. A host reaches the table through a byte-wide synchronous register port. The port has four registers: a write-entry pointer, a read-entry pointer, a pixel mask and a single data register.

To load colours, the host sets the write pointer and then writes bytes to the data register. A three-state component counter sends each byte to red, then green, then blue, and moves the pointer to the next entry after blue. Reads work the same way from the read pointer, with a counter of their own.

A pixel-side port runs in parallel. Every cycle it ANDs the incoming pixel value with the mask, looks up that entry, and presents the colour one cycle later.

Top module: `colour_lut_port`

## Requirements
- R1: A bus write to address 0 loads the write pointer from data bits 7:0 and sets the write component to red.
- R2: Bus writes to address 1 store into the current write entry in the order red, green, blue. The write pointer advances by one after the blue byte and stays put after the red and green bytes.
- R3: The write pointer wraps modulo 256. After 256 full triplets that start at entry 0, a read of address 0 returns 0.
- R4: A bus write to address 3 loads the read pointer and sets the read component to red. Bus reads of address 1 return red, green and blue of the read entry in turn, and the read pointer advances after blue.
- R5: Only data bits 5:0 of a byte are stored. Bus reads of address 1 return the stored 6 bits in bits 5:0, with bits 7:6 at zero.
- R6: The pixel output is {red[17:12], green[11:6], blue[5:0]} of entry (pix_idx AND mask). It appears one cycle after pix_idx is presented. The mask is at address 2 and resets to 0xFF.
- R7: When a data write and a pixel lookup hit the same entry in the same cycle, the pixel output shows the old colour. The new colour shows on the following lookup.
- R8: Write-side and read-side sequences keep separate pointers and component counters, so interleaving data writes and data reads leaves both sequences intact.
- R9: A bus read (bus_en high, bus_we low) raises bus_rvalid and presents bus_rdata in the next cycle. Reads of addresses 0, 2 and 3 return the write pointer, the mask and the read pointer. After reset both pointers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Access is a write when high, a read when low |
| bus_addr | input | 2 | Register select: 0 write pointer, 1 data, 2 mask, 3 read pointer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response, one cycle after a read |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 18 | Looked-up colour {red, green, blue} |

## Verification
A host data write and a pixel lookup can hit the same table entry in the same clock. The bench holds pix_idx on an entry and then issues the red-channel write to that entry. It checks that the pixel output in the cycle after the write still carries the old red value and that the next cycle shows the new one. A second overlap, between a write-side byte and a read-side byte, is provoked by alternating them on one entry pair. The returned triplet and both final pointers are compared with the bench's own table model.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int NUM_CHAN = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    SEL_WPTR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_MASK = 2'd2,
    SEL_RPTR = 2'd3
  } reg_sel_t;

endpackage

// File: rtl/clut_seq.sv
// Entry pointer with a three-step component counter.
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_t           phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          idx   <= idx + IDX_W'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/clut_ram.sv
// One colour channel: one write port, a free-running lookup port and an
// enabled host read port; both reads return pre-write data.
module clut_ram #(
  parameter int AW = 8,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_q <= mem[a_addr];
    if (b_en) b_q <= mem[b_addr];
  end

endmodule

// File: rtl/colour_lut_port.sv
module colour_lut_port
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int CHAN_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [1:0]                 bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  output logic                       bus_rvalid,
  input  logic [IDX_W-1:0]           pix_idx,
  output logic [NUM_CHAN*CHAN_W-1:0] pix_rgb
);

  reg_sel_t         sel;
  logic             acc_wr, acc_rd;
  logic             wr_load, wr_step, rd_load, rd_step;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  phase_t           wr_phase, rd_phase;
  logic [IDX_W-1:0] mask_q;
  logic [IDX_W-1:0] look_addr;

  assign sel     = reg_sel_t'(bus_addr);
  assign acc_wr  = bus_en & bus_we;
  assign acc_rd  = bus_en & ~bus_we;
  assign wr_load = acc_wr && (sel == SEL_WPTR);
  assign wr_step = acc_wr && (sel == SEL_DATA);
  assign rd_load = acc_wr && (sel == SEL_RPTR);
  assign rd_step = acc_rd && (sel == SEL_DATA);

  clut_seq #(.IDX_W(IDX_W)) u_wseq (
    .clk(clk), .rst(rst), .load(wr_load), .load_val(bus_wdata[IDX_W-1:0]),
    .step(wr_step), .idx(wr_idx), .phase(wr_phase)
  );

  clut_seq #(.IDX_W(IDX_W)) u_rseq (
    .clk(clk), .rst(rst), .load(rd_load), .load_val(bus_wdata[IDX_W-1:0]),
    .step(rd_step), .idx(rd_idx), .phase(rd_phase)
  );

  always_ff @(posedge clk) begin
    if (rst)                                mask_q <= '1;
    else if (acc_wr && (sel == SEL_MASK))   mask_q <= bus_wdata[IDX_W-1:0];
  end

  assign look_addr = pix_idx & mask_q;

  logic [CHAN_W-1:0] b_q [NUM_CHAN];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic          ch_we;
    logic [CHAN_W-1:0] a_q;
    assign ch_we = wr_step && (wr_phase == phase_t'(c));
    clut_ram #(.AW(IDX_W), .DW(CHAN_W)) u_ram (
      .clk(clk), .we(ch_we), .waddr(wr_idx), .wdata(bus_wdata[CHAN_W-1:0]),
      .a_addr(look_addr), .a_q(a_q),
      .b_en(rd_step), .b_addr(rd_idx), .b_q(b_q[c])
    );
    assign pix_rgb[(NUM_CHAN-1-c)*CHAN_W +: CHAN_W] = a_q;
  end

  // Read response
  reg_sel_t         src_q;
  phase_t           ch_q;
  logic [BUS_W-1:0] hold_q;
  logic [BUS_W-1:0] reg_val;
  logic [BUS_W-1:0] chan_val;

  always_comb begin
    reg_val = '0;
    case (sel)
      SEL_WPTR: reg_val[IDX_W-1:0] = wr_idx;
      SEL_MASK: reg_val[IDX_W-1:0] = mask_q;
      SEL_RPTR: reg_val[IDX_W-1:0] = rd_idx;
      default:  reg_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      src_q      <= SEL_WPTR;
      ch_q       <= PH_RED;
      hold_q     <= '0;
    end else begin
      bus_rvalid <= acc_rd;
      if (acc_rd) begin
        src_q  <= sel;
        ch_q   <= rd_phase;
        hold_q <= reg_val;
      end
    end
  end

  always_comb begin
    chan_val = '0;
    case (ch_q)
      PH_RED:  chan_val[CHAN_W-1:0] = b_q[0];
      PH_GRN:  chan_val[CHAN_W-1:0] = b_q[1];
      default: chan_val[CHAN_W-1:0] = b_q[2];
    endcase
  end

  assign bus_rdata = (src_q == SEL_DATA) ? chan_val : hold_q;

endmodule

// File: rtl/clut_checker.sv
module clut_checker #(
  parameter int IDX_W  = 8,
  parameter int CHAN_W = 6,
  parameter int BUS_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_en,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             bus_rvalid,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_phase,
  input logic [IDX_W-1:0] rd_idx,
  input logic [1:0]       rd_phase
);

  logic wl, ws, rl, rs, rdacc;
  assign wl    = bus_en && bus_we && (bus_addr == 2'd0);
  assign ws    = bus_en && bus_we && (bus_addr == 2'd1);
  assign rl    = bus_en && bus_we && (bus_addr == 2'd3);
  assign rs    = bus_en && !bus_we && (bus_addr == 2'd1);
  assign rdacc = bus_en && !bus_we;

  a_r1_load_ptr: assert property (@(posedge clk) disable iff (rst)
    wl |=> (wr_phase == 2'd0) && (wr_idx == $past(bus_wdata[IDX_W-1:0])));

  a_r2_mid_step: assert property (@(posedge clk) disable iff (rst)
    (ws && wr_phase != 2'd2) |=> (wr_phase == 2'($past(wr_phase) + 2'd1)) && $stable(wr_idx));

  a_r2_blue_adv: assert property (@(posedge clk) disable iff (rst)
    (ws && wr_phase == 2'd2) |=> (wr_phase == 2'd0) && (wr_idx == IDX_W'($past(wr_idx) + 1)));

  a_r2_phase_legal: assert property (@(posedge clk) disable iff (rst)
    (wr_phase != 2'd3) && (rd_phase != 2'd3));

  a_r4_load_ptr: assert property (@(posedge clk) disable iff (rst)
    rl |=> (rd_phase == 2'd0) && (rd_idx == $past(bus_wdata[IDX_W-1:0])));

  a_r4_blue_adv: assert property (@(posedge clk) disable iff (rst)
    (rs && rd_phase == 2'd2) |=> (rd_phase == 2'd0) && (rd_idx == IDX_W'($past(rd_idx) + 1)));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rs |=> (bus_rdata[BUS_W-1:CHAN_W] == '0));

  a_r8_wr_keeps_rd: assert property (@(posedge clk) disable iff (rst)
    ws |=> $stable(rd_idx) && $stable(rd_phase));

  a_r8_rd_keeps_wr: assert property (@(posedge clk) disable iff (rst)
    rs |=> $stable(wr_idx) && $stable(wr_phase));

  a_r9_rvalid_rise: assert property (@(posedge clk) disable iff (rst)
    rdacc |=> bus_rvalid);

  a_r9_rvalid_low: assert property (@(posedge clk) disable iff (rst)
    !rdacc |=> !bus_rvalid);

endmodule

bind colour_lut_port clut_checker #(.IDX_W(IDX_W), .CHAN_W(CHAN_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .wr_idx(wr_idx), .wr_phase(wr_phase), .rd_idx(rd_idx), .rd_phase(rd_phase)
);

// File: tb/colour_lut_port_bench.sv
`timescale 1ns/1ps
module colour_lut_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  pix_idx = 8'd0;
  logic [17:0] pix_rgb;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [5:0] mr [256];
  logic [5:0] mg [256];
  logic [5:0] mb [256];

  always #2.5 clk = ~clk;

  colour_lut_port u_colour_lut_port (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  function automatic logic [7:0] pat(input int i, input int c);
    return 8'((i * 29 + c * 71 + 5) & 255);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_en = 1'b0;
  endtask

  task automatic put_rgb(input int e, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    bus_wr(2'd1, r); bus_wr(2'd1, g); bus_wr(2'd1, b);
    mr[e] = r[5:0]; mg[e] = g[5:0]; mb[e] = b[5:0];
  endtask

  function automatic logic [17:0] exp_rgb(input int e);
    return {mr[e], mg[e], mb[e]};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 rvalid idle after reset", 32'(bus_rvalid), 32'd0);

    // Reset state of registers
    bus_rd(2'd0, d, v); check("R9 wptr reset", 32'(d), 32'd0);
    check("R9 rvalid after read", 32'(v), 32'd1);
    bus_rd(2'd3, d, v); check("R9 rptr reset", 32'(d), 32'd0);
    bus_rd(2'd2, d, v); check("R6 mask reset", 32'(d), 32'hFF);
    bus_wr(2'd2, 8'hFF);
    @(negedge clk);
    check("R9 rvalid low after write", 32'(bus_rvalid), 32'd0);

    // R2 / R3: fill all entries from 0 with full bytes (top bits set)
    bus_wr(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      put_rgb(i, pat(i, 0) | 8'hC0, pat(i, 1), pat(i, 2) | 8'h40);
      if (i == 0) begin
        bus_rd(2'd0, d, v); check("R2 wptr after first triplet", 32'(d), 32'd1);
      end
    end
    bus_rd(2'd0, d, v); check("R3 wptr wrap to zero", 32'(d), 32'd0);

    // R4 / R5: read back whole table via data register
    bus_wr(2'd3, 8'd0);
    for (int i = 0; i < 256; i++) begin
      bus_rd(2'd1, d, v); check("R4 R5 red readback", 32'(d), 32'(mr[i]));
      bus_rd(2'd1, d, v); check("R4 R5 green readback", 32'(d), 32'(mg[i]));
      bus_rd(2'd1, d, v); check("R4 R5 blue readback", 32'(d), 32'(mb[i]));
    end
    bus_rd(2'd3, d, v); check("R4 rptr wrap", 32'(d), 32'd0);

    // R2: partial triplet does not advance pointer
    bus_wr(2'd0, 8'd40);
    bus_wr(2'd1, 8'h11); bus_wr(2'd1, 8'h22);
    bus_rd(2'd0, d, v); check("R2 no advance mid triplet", 32'(d), 32'd40);
    // R1: reload restarts at red
    bus_wr(2'd0, 8'd40);
    put_rgb(40, 8'h05, 8'h2A, 8'h3F);
    bus_rd(2'd0, d, v); check("R1 wptr after reload triplet", 32'(d), 32'd41);
    bus_wr(2'd3, 8'd40);
    bus_rd(2'd1, d, v); check("R1 red restarted", 32'(d), 32'h05);
    bus_rd(2'd1, d, v); check("R1 green restarted", 32'(d), 32'h2A);
    bus_rd(2'd1, d, v); check("R1 blue restarted", 32'(d), 32'h3F);
    bus_rd(2'd3, d, v); check("R4 rptr advanced", 32'(d), 32'd41);

    // R6: pixel sweep with full mask
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); pix_idx = 8'(p);
      @(negedge clk); check("R6 lookup mask FF", 32'(pix_rgb), 32'(exp_rgb(p)));
    end
    bus_wr(2'd2, 8'h0F);
    bus_rd(2'd2, d, v); check("R9 mask readback", 32'(d), 32'h0F);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); pix_idx = 8'(p);
      @(negedge clk); check("R6 lookup mask 0F", 32'(pix_rgb), 32'(exp_rgb(p & 15)));
    end
    bus_wr(2'd2, 8'h00);
    for (int p = 250; p < 256; p++) begin
      @(negedge clk); pix_idx = 8'(p);
      @(negedge clk); check("R6 lookup mask 00", 32'(pix_rgb), 32'(exp_rgb(0)));
    end
    bus_wr(2'd2, 8'hFF);

    // R7: write and lookup of the same entry in one cycle
    bus_wr(2'd0, 8'd77);
    @(negedge clk); pix_idx = 8'd77;
    @(negedge clk); check("R7 baseline", 32'(pix_rgb), 32'(exp_rgb(77)));
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = {2'b00, ~mr[77]};
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    check("R7 old colour same cycle", 32'(pix_rgb), 32'(exp_rgb(77)));
    mr[77] = ~mr[77];
    @(negedge clk);
    check("R7 new colour next cycle", 32'(pix_rgb), 32'(exp_rgb(77)));
    bus_wr(2'd1, {2'b00, mg[77]});
    bus_wr(2'd1, {2'b00, mb[77]});

    // R8: interleave write sequence on 20 with read sequence on 30
    bus_wr(2'd0, 8'd20);
    bus_wr(2'd3, 8'd30);
    bus_wr(2'd1, 8'h01); bus_rd(2'd1, d, v); check("R8 interleaved red", 32'(d), 32'(mr[30]));
    bus_wr(2'd1, 8'h02); bus_rd(2'd1, d, v); check("R8 interleaved green", 32'(d), 32'(mg[30]));
    bus_wr(2'd1, 8'h03); bus_rd(2'd1, d, v); check("R8 interleaved blue", 32'(d), 32'(mb[30]));
    mr[20] = 6'h01; mg[20] = 6'h02; mb[20] = 6'h03;
    bus_rd(2'd0, d, v); check("R8 wptr intact", 32'(d), 32'd21);
    bus_rd(2'd3, d, v); check("R8 rptr intact", 32'(d), 32'd31);
    @(negedge clk); pix_idx = 8'd20;
    @(negedge clk); check("R8 written entry via pixel port", 32'(pix_rgb), 32'(exp_rgb(20)));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule